// File: doc/BRIEF.md
# Colour Subcarrier Divider with Line-Rate Phase Comparator

This block produces the colour subcarrier square wave for a camera sync generator and compares the phase of an external 4fsc oscillator against the master pixel clock. All logic runs on one system clock. The master clock and the 4fsc clock arrive as single-cycle enable strobes (`mst_tick`, `fsc_tick`), one strobe per edge of each source.

The subcarrier counter divides by `SC_DIV` (default 4). Its source depends on the video standard and on the sync mode. In 525-line mode with internal sync it counts master-clock strobes. In 525-line mode with external sync, and in 625-line mode, it counts 4fsc strobes. A low level on `sc_stop_n` clears the counter and holds the output low.

In 625-line mode two divider chains bring both clocks down to roughly line rate:
- The 4fsc chain divides by `FSC_PRE` and then by `LINE_DIV`.
- The master chain divides by `MST_PRE` and then by `LINE_DIV`.

A three-state phase-frequency detector compares the two reference pulses. Its output is a level plus an output-enable, so an off-chip loop filter can pull 4fsc into lock. The sense of the level is chosen for a passive or an active filter. In 525-line mode the comparator chains are held cleared and the output is not driven.

Top module: `sc_subcarrier_pd`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `sc_out` = 0, `cmp_oe` = 0 and `cmp_lvl` = 0.
- R2: With `std_pal`=0 and `ext_sync`=0, the subcarrier counter advances once per `mst_tick` strobe. After k counted strobes, `sc_out` = 1 exactly when (k mod `SC_DIV`) >= `SC_DIV`/2.
- R3: With `std_pal`=1 or `ext_sync`=1, the subcarrier counter advances once per `fsc_tick` strobe with the same waveform as R2, and `mst_tick` has no effect on `sc_out`.
- R4: A cycle with `sc_stop_n`=0 clears the subcarrier count to zero, so `sc_out` = 0 after that edge. Counting resumes from phase 0 once `sc_stop_n` returns to 1.
- R5: In 625-line mode, a 4fsc reference pulse occurs on every (`FSC_PRE`*`LINE_DIV`)-th `fsc_tick`. A master reference pulse occurs on every (`MST_PRE`*`LINE_DIV`)-th `mst_tick`. Both counts start at the first strobe after `std_pal` goes to 1.
- R6: With `pol_active`=0: a master reference pulse with no pending state makes the output drive `cmp_lvl`=1 (4fsc lags) until a 4fsc pulse arrives. A 4fsc pulse with no pending state drives `cmp_lvl`=0 (4fsc leads) until a master pulse arrives. The arriving pulse returns the output to undriven.
- R7: With `pol_active`=1, `cmp_lvl` is inverted relative to R6 whenever `cmp_oe`=1.
- R8: When both reference pulses fall in the same clock cycle, the detector returns to undriven: `cmp_oe`=0 and `cmp_lvl`=0 after that edge.
- R9: With `std_pal`=0, after each edge `cmp_oe`=0, and both comparator divider chains are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_tick | input | 1 | One-cycle strobe per master clock edge |
| fsc_tick | input | 1 | One-cycle strobe per 4fsc clock edge |
| std_pal | input | 1 | 1 = 625-line standard, 0 = 525-line standard |
| ext_sync | input | 1 | 1 = external sync mode, 0 = internal |
| sc_stop_n | input | 1 | 0 = stop and clear the subcarrier path |
| pol_active | input | 1 | 0 = passive filter sense, 1 = active (inverted) |
| sc_out | output | 1 | Subcarrier square wave |
| cmp_oe | output | 1 | Comparator output driven when 1 |
| cmp_lvl | output | 1 | Comparator level (0 when not driven) |

## Verification
The bench sweeps all sixteen combinations of standard, sync mode, polarity and strobe pattern, using a short line divider so that many reference periods fit into each segment. Each 625-line segment follows a 525-line one, so the comparator chains start from a known zero. Mismatched strobe densities make the master or the 4fsc pulse arrive first, which separates the lag state from the lead state. One chosen pattern puts both pulses in the same cycle to exercise the undriven case. A stop window inside every segment tells a true clear apart from a mere pause, because the phase after release must restart at zero.

// File: rtl/sc_pkg.sv
// Shared types for the subcarrier divider and phase comparator.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package sc_pkg;
    // Phase detector state: idle (undriven), 4fsc lagging, 4fsc leading
    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_LAG  = 2'd1,
        PD_LEAD = 2'd2
    } pd_state_t;
endpackage

// File: rtl/sc_mod_counter.sv
// Modulo-N counter advanced by an enable strobe; emits a one-cycle
// wrap strobe in the cycle its last count is consumed.
// Assumes: N >= 2; clr has priority over en.
module sc_mod_counter #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic wrap
);
    localparam int W = (N > 1) ? $clog2(N) : 1;
    localparam logic [W-1:0] LAST = W'(N - 1);

    logic [W-1:0] count;

    // wrap strobe: last count consumed this cycle
    assign wrap = en && !clr && (count == LAST);

    // count register: clear, hold or advance modulo N
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (en)
            count <= (count == LAST) ? '0 : count + 1'b1;
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);
    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(count));
endmodule

// File: rtl/sc_div_chain.sv
// Two cascaded modulo counters: a prescaler followed by a line-rate
// divider. Produces one reference strobe every PRE*LINE enables.
// Assumes: both parameters >= 2; clr clears both stages together.
module sc_div_chain #(
    parameter int PRE  = 5,
    parameter int LINE = 227
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic ref_pulse
);
    logic pre_wrap;

    sc_mod_counter #(.N(PRE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (en),
        .wrap  (pre_wrap)
    );

    sc_mod_counter #(.N(LINE)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (pre_wrap),
        .wrap  (ref_pulse)
    );
endmodule

// File: rtl/sc_wave_gen.sv
// Subcarrier square-wave generator: divides the selected tick stream
// by DIV; output is high for the upper half of the count.
// Assumes: DIV even and >= 2; run low clears the phase to zero.
module sc_wave_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic sc_out
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);
    localparam logic [W-1:0] HALF = W'(DIV / 2);

    logic [W-1:0] phase;

    // phase counter: cleared while stopped, advances on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            phase <= '0;
        else if (tick)
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end

    // square wave from the upper half of the phase
    assign sc_out = (phase >= HALF);

    // R4
    sc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sc_out);
    // R2
    sc_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(sc_out));
endmodule

// File: rtl/sc_phase_det.sv
// Three-state phase-frequency detector on two reference strobes.
// A master strobe first means 4fsc lags; a 4fsc strobe first means it
// leads; the later strobe (or both together) returns to undriven.
// Assumes: en low forces idle; pol inverts the driven level.
module sc_phase_det
    import sc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pol,
    input  logic ref_m,
    input  logic ref_f,
    output logic oe,
    output logic lvl
);
    pd_state_t state, state_nx;

    // next state from the two strobes
    always_comb begin
        state_nx = state;
        if (ref_m && ref_f)
            state_nx = PD_IDLE;
        else if (ref_m)
            state_nx = (state == PD_LEAD) ? PD_IDLE : PD_LAG;
        else if (ref_f)
            state_nx = (state == PD_LAG) ? PD_IDLE : PD_LEAD;
    end

    // state register, held idle outside the comparing standard
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            state <= PD_IDLE;
        else
            state <= state_nx;
    end

    // output drive and polarity-selected level
    always_comb begin
        oe  = (state != PD_IDLE);
        lvl = 1'b0;
        if (state == PD_LAG)
            lvl = !pol;
        else if (state == PD_LEAD)
            lvl = pol;
    end

    // R9
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !oe);
    // R8
    pd_coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ref_m && ref_f) |=> (!oe && !lvl));
    // R6
    pd_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ref_m && !ref_f && !oe) |=> (oe && (lvl != pol)));
    // R7
    pd_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ref_f && !ref_m && !oe) |=> (oe && (lvl == pol)));
endmodule

// File: rtl/sc_subcarrier_pd.sv
// Top: subcarrier source selection and divider, plus the two line-rate
// divider chains feeding the phase detector in 625-line mode.
// Assumes: mst_tick / fsc_tick are single-cycle strobes on clk.
module sc_subcarrier_pd #(
    parameter int SC_DIV   = 4,
    parameter int FSC_PRE  = 5,
    parameter int MST_PRE  = 4,
    parameter int LINE_DIV = 227
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mst_tick,
    input  logic fsc_tick,
    input  logic std_pal,
    input  logic ext_sync,
    input  logic sc_stop_n,
    input  logic pol_active,
    output logic sc_out,
    output logic cmp_oe,
    output logic cmp_lvl
);
    logic use_fsc;
    logic sc_tick;
    logic fsc_ref;
    logic mst_ref;
    logic cmp_off;

    // subcarrier source: master only in 525-line internal mode
    assign use_fsc = std_pal || ext_sync;
    assign sc_tick = use_fsc ? fsc_tick : mst_tick;
    // comparator chains are parked outside 625-line mode
    assign cmp_off = !std_pal;

    sc_wave_gen #(.DIV(SC_DIV)) u_wave (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (sc_stop_n),
        .tick   (sc_tick),
        .sc_out (sc_out)
    );

    sc_div_chain #(.PRE(FSC_PRE), .LINE(LINE_DIV)) u_fsc_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cmp_off),
        .en        (fsc_tick),
        .ref_pulse (fsc_ref)
    );

    sc_div_chain #(.PRE(MST_PRE), .LINE(LINE_DIV)) u_mst_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cmp_off),
        .en        (mst_tick),
        .ref_pulse (mst_ref)
    );

    sc_phase_det u_pd (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (std_pal),
        .pol   (pol_active),
        .ref_m (mst_ref),
        .ref_f (fsc_ref),
        .oe    (cmp_oe),
        .lvl   (cmp_lvl)
    );

    // R3
    top_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_fsc && sc_stop_n && !fsc_tick) |=> $stable(sc_out));
    // R9
    top_ref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !std_pal |-> (!fsc_ref && !mst_ref));
endmodule

// File: tb/sc_subcarrier_pd_tb.sv
// Sweep bench: 16 configurations, expected values from arithmetic
// tick counts; short line divider for dense comparator activity.
module sc_subcarrier_pd_tb;
    localparam int SCD  = 4;
    localparam int FPRE = 5;
    localparam int MPRE = 4;
    localparam int LDIV = 3;
    localparam int SEG  = 120;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mst_tick = 1'b0, fsc_tick = 1'b0;
    logic std_pal = 1'b0, ext_sync = 1'b0, sc_stop_n = 1'b1, pol_active = 1'b0;
    logic sc_out, cmp_oe, cmp_lvl;

    int n_chk = 0, n_fail = 0;
    int k_sc = 0, mcnt = 0, fcnt = 0, st = 0;
    int n_lag = 0, n_lead = 0, n_coin = 0, n_ref = 0;

    always #2 clk = ~clk;

    sc_subcarrier_pd #(.SC_DIV(SCD), .FSC_PRE(FPRE), .MST_PRE(MPRE),
                       .LINE_DIV(LDIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .mst_tick(mst_tick), .fsc_tick(fsc_tick),
        .std_pal(std_pal), .ext_sync(ext_sync), .sc_stop_n(sc_stop_n),
        .pol_active(pol_active), .sc_out(sc_out), .cmp_oe(cmp_oe),
        .cmp_lvl(cmp_lvl));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit pat(input int sel, input int c);
        case (sel)
            0: return 1'b1;
            1: return (c % 5) != 0;
            2: return (c % 3) != 0;
            default: return (c % 4) != 1;
        endcase
    endfunction

    // compare outputs with the model state predicted for this edge
    task automatic check_outputs();
        int exp_lvl;
        string sc_tag;
        exp_lvl = (st == 1) ? int'(!pol_active) : (st == 2) ? int'(pol_active) : 0;
        if (!sc_stop_n) sc_tag = "R4";
        else if (!std_pal && !ext_sync) sc_tag = "R2";
        else sc_tag = "R3";
        chk(sc_out == ((k_sc % SCD) >= SCD / 2), sc_tag, sc_out, int'((k_sc % SCD) >= SCD / 2));
        chk(cmp_oe == (st != 0), std_pal ? "R8" : "R9", cmp_oe, int'(st != 0));
        chk(cmp_lvl == exp_lvl, pol_active ? "R7" : "R6", cmp_lvl, exp_lvl);
    endtask

    // advance the model by the inputs applied for the coming edge
    task automatic model_step();
        bit src, me, fe;
        src = (std_pal || ext_sync) ? fsc_tick : mst_tick;
        if (!sc_stop_n) k_sc = 0;
        else if (src) k_sc = (k_sc + 1) % SCD;
        if (!std_pal) begin
            mcnt = 0; fcnt = 0; st = 0;
        end else begin
            me = mst_tick && (mcnt == MPRE * LDIV - 1);
            fe = fsc_tick && (fcnt == FPRE * LDIV - 1);
            if (mst_tick) mcnt = (mcnt + 1) % (MPRE * LDIV);
            if (fsc_tick) fcnt = (fcnt + 1) % (FPRE * LDIV);
            if (me || fe) n_ref++;
            if (me && fe) begin st = 0; n_coin++; end
            else if (me) begin st = (st == 2) ? 0 : 1; if (st == 1) n_lag++; end
            else if (fe) begin st = (st == 1) ? 0 : 2; if (st == 2) n_lead++; end
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state with active strobes present
        mst_tick = 1'b1; fsc_tick = 1'b1; std_pal = 1'b1;
        repeat (3) @(negedge clk);
        chk(sc_out == 1'b0, "R1", sc_out, 0);
        chk(cmp_oe == 1'b0, "R1", cmp_oe, 0);
        chk(cmp_lvl == 1'b0, "R1", cmp_lvl, 0);
        std_pal = 1'b0; mst_tick = 1'b0; fsc_tick = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_step();
        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int c = 0; c < SEG; c++) begin
                @(negedge clk);
                check_outputs();
                std_pal    = cfg[0];
                pol_active = cfg[2];
                ext_sync   = cfg[3];
                sc_stop_n  = !(c >= 60 && c < 64);
                mst_tick   = pat(int'(cfg[2:1]), c);
                fsc_tick   = pat(cfg[3] ? 2 : 0, c);
                model_step();
            end
        end
        @(negedge clk);
        check_outputs();
        // R5: reference pulses occurred; R6/R8 pattern coverage
        chk(n_ref > 0, "R5", n_ref, 1);
        chk(n_lag > 0, "R6", n_lag, 1);
        chk(n_lead > 0, "R7", n_lead, 1);
        chk(n_coin > 0, "R8", n_coin, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule